// File: doc/BRIEF.md
# Address Region Decoder with Store Lock

This block sits between a 32-bit processor and its memories and peripheral ports. For every access it looks at the address and turns it into a one-hot target select and an offset into that target. Address bits 28:16 form a 13-bit page key. Because bits 31:29 are ignored, the cached, uncached and physical segment views of one location all decode the same way.

The block also holds one memory-mapped control word. Certain values stored to that word put the block into a locked state. While it is locked, stores to main RAM never reach the RAM, and full-word RAM loads read back as zero. Other values written there are kept but do not change the lock. The memories and peripherals stay outside the block. It only steers the access, gates the write strobe and shapes the read data it passes back.

Top module: `region_decoder`

## Requirements
- R1: Keys 0x0000 to 0x007F select main RAM on `sel` bit 0, whatever address bits 31:29 hold. The offset is address bits 20:0, so the 2 MB RAM repeats four times across the 128 pages. Key 0x0080 maps to nothing.
- R2: Key 0x1F80 selects scratchpad on `sel` bit 1 when address bits 15:0 are below 0x1000, with offset bits 11:0. Otherwise it selects the hardware-register port on `sel` bit 2, with offset bits 15:0.
- R3: Key 0x1F40 selects the auxiliary port on bit 3, key 0x1000 the expansion port on bit 4, key 0x1F90 the sound port on bit 5, and key 0x1D00 the inter-processor bank on bit 6. Each of these has offset bits 15:0.
- R4: Keys 0x1FC0 to 0x1FFF select boot ROM on bit 7, with offset bits 21:0. Keys 0x1E00 to 0x1E03 select the second ROM on bit 8, with offset bits 17:0. A store to either ROM never raises `tgt_we`.
- R5: The exact address 0xFFFE0130 selects the control word on bit 9, ahead of the boot ROM decode. A 32-bit store (`size`=2) there saves `wdata` at the clock edge. A load of any size returns the saved value. 8-bit and 16-bit stores there are ignored. The control word never raises `tgt_we`.
- R6: A 32-bit store to the control word of 0x800, 0x804, 0xC00, 0xC04, 0xCC0, 0xCC4 or 0x0C4 sets the lock from the next cycle on.
- R7: A 32-bit store of 0x1E988 or 0x1EDD8 clears the lock. Any other value is saved but leaves the lock as it was.
- R8: While locked, RAM stores of every size keep `tgt_we` low and 32-bit RAM loads return zero. 8-bit and 16-bit RAM loads still pass `tgt_rdata`. Stores to other regions are unaffected.
- R9: An address that maps to no region gives `sel`=0, offset 0, `rdata`=0 and `tgt_we` low.
- R10: After reset the lock is clear and the control word reads zero.
- R11: At most one `sel` bit is ever high. `rdata` is zero when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Access address |
| rd_en | input | 1 | Load strobe |
| wr_en | input | 1 | Store strobe |
| size | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| wdata | input | 32 | Store data |
| tgt_rdata | input | 32 | Load data from the selected target |
| sel | output | 10 | One-hot region select (bit map in R1 to R5) |
| offset | output | 22 | Offset inside the selected region |
| tgt_we | output | 1 | Store strobe to the selected target, after lock and ROM gating |
| rdata | output | 32 | Load data returned to the processor |

## Verification
The control-word store and the boot ROM decode both claim addresses whose key is 0x1FFE. The bench drives stores and loads at 0xFFFE0130 and at its ROM neighbours 0xBFFE0130 and 0xFFFE0134, checking `sel` and the offset. A lock code stored to a ROM alias must leave the lock unchanged. The lock update and the very next RAM store also meet at one edge. The bench issues the lock store and, in the following cycle, a RAM store, and judges `tgt_we` in that cycle.

// File: rtl/region_decoder.sv
module region_decoder #(
  parameter logic [31:0] CTRL_ADDR     = 32'hFFFE_0130,
  parameter int          RAM_PAGE_BITS = 5,
  parameter int          RAM_WIN_PAGES = 128,
  parameter int          BOOT_PAGES    = 64,
  parameter int          ROM2_PAGES    = 4,
  parameter int          OFS_W         = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  input  logic [31:0]      tgt_rdata,
  output logic [9:0]       sel,
  output logic [OFS_W-1:0] offset,
  output logic             tgt_we,
  output logic [31:0]      rdata
);

  localparam int RG_RAM = 0, RG_SPAD = 1, RG_HW = 2, RG_AUX = 3, RG_EXP = 4;
  localparam int RG_SND = 5, RG_IPC = 6, RG_BOOT = 7, RG_ROM2 = 8, RG_CTRL = 9;

  localparam logic [12:0] K_RAM_HI  = 13'(RAM_WIN_PAGES - 1);
  localparam logic [12:0] K_LOCAL   = 13'h1F80;
  localparam logic [12:0] K_AUX     = 13'h1F40;
  localparam logic [12:0] K_EXP     = 13'h1000;
  localparam logic [12:0] K_SND     = 13'h1F90;
  localparam logic [12:0] K_IPC     = 13'h1D00;
  localparam logic [12:0] K_BOOT_LO = 13'h1FC0;
  localparam logic [12:0] K_BOOT_HI = 13'(13'h1FC0 + BOOT_PAGES - 1);
  localparam logic [12:0] K_ROM2_LO = 13'h1E00;
  localparam logic [12:0] K_ROM2_HI = 13'(13'h1E00 + ROM2_PAGES - 1);

  localparam logic [31:0] M_RAM  = (32'd1 << (16 + RAM_PAGE_BITS)) - 32'd1;
  localparam logic [31:0] M_SPAD = 32'h0000_0FFF;
  localparam logic [31:0] M_PAGE = 32'h0000_FFFF;
  localparam logic [31:0] M_BOOT = (32'(BOOT_PAGES) << 16) - 32'd1;
  localparam logic [31:0] M_ROM2 = (32'(ROM2_PAGES) << 16) - 32'd1;

  logic [12:0] key;
  logic [31:0] mask;
  logic [31:0] ctrl_q;
  logic        lock_q;
  logic        ctrl_wr;
  logic        code_lock, code_unlock;

  assign key = addr[28:16];

  always_comb begin
    sel  = '0;
    mask = '0;
    if (addr == CTRL_ADDR) begin
      sel[RG_CTRL] = 1'b1;
    end else if (key <= K_RAM_HI) begin
      sel[RG_RAM] = 1'b1;
      mask        = M_RAM;
    end else if (key == K_LOCAL) begin
      if (addr[15:0] < 16'h1000) begin
        sel[RG_SPAD] = 1'b1;
        mask         = M_SPAD;
      end else begin
        sel[RG_HW] = 1'b1;
        mask       = M_PAGE;
      end
    end else if (key == K_AUX) begin
      sel[RG_AUX] = 1'b1;
      mask        = M_PAGE;
    end else if (key == K_EXP) begin
      sel[RG_EXP] = 1'b1;
      mask        = M_PAGE;
    end else if (key == K_SND) begin
      sel[RG_SND] = 1'b1;
      mask        = M_PAGE;
    end else if (key == K_IPC) begin
      sel[RG_IPC] = 1'b1;
      mask        = M_PAGE;
    end else if (key >= K_BOOT_LO && key <= K_BOOT_HI) begin
      sel[RG_BOOT] = 1'b1;
      mask         = M_BOOT;
    end else if (key >= K_ROM2_LO && key <= K_ROM2_HI) begin
      sel[RG_ROM2] = 1'b1;
      mask         = M_ROM2;
    end
  end

  assign offset = OFS_W'(addr & mask);

  always_comb begin
    code_lock   = 1'b0;
    code_unlock = 1'b0;
    case (wdata)
      32'h0000_0800, 32'h0000_0804, 32'h0000_0C00, 32'h0000_0C04,
      32'h0000_0CC0, 32'h0000_0CC4, 32'h0000_00C4: code_lock   = 1'b1;
      32'h0001_E988, 32'h0001_EDD8:                code_unlock = 1'b1;
      default: ;
    endcase
  end

  assign ctrl_wr = wr_en && (size == 2'd2) && sel[RG_CTRL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
      if (code_lock)        lock_q <= 1'b1;
      else if (code_unlock) lock_q <= 1'b0;
    end
  end

  assign tgt_we = wr_en && (|sel) && !sel[RG_CTRL] && !sel[RG_BOOT] &&
                  !sel[RG_ROM2] && !(sel[RG_RAM] && lock_q);

  always_comb begin
    if (!rd_en || sel == '0)                         rdata = '0;
    else if (sel[RG_CTRL])                           rdata = ctrl_q;
    else if (sel[RG_RAM] && lock_q && size == 2'd2)  rdata = '0;
    else                                             rdata = tgt_rdata;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R11

  AST_ROM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[RG_BOOT] || sel[RG_ROM2]) |-> !tgt_we); // R4

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && size == 2'd2 && addr == CTRL_ADDR) |=> $stable(ctrl_q)); // R5

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == 2'd2 && addr == CTRL_ADDR && code_lock) |=> lock_q); // R6

  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == 2'd2 && addr == CTRL_ADDR && code_unlock) |=> !lock_q); // R7

  AST_LOCKED_RAM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && sel[RG_RAM] && rd_en && size == 2'd2) |-> rdata == 32'd0); // R8

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (offset == '0 && rdata == 32'd0 && !tgt_we)); // R9

endmodule

// File: tb/region_decoder_tb.sv
module region_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] tgt_rdata = 32'hA5A5_1234;
  logic [9:0]  sel;
  logic [21:0] offset;
  logic        tgt_we;
  logic [31:0] rdata;

  int n_chk = 0, n_err = 0;
  localparam logic [31:0] CTRL = 32'hFFFE_0130;
  localparam logic [31:0] RAMA = 32'h8000_1000;

  always #2.5 clk = ~clk;

  region_decoder u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .size(size), .wdata(wdata), .tgt_rdata(tgt_rdata),
    .sel(sel), .offset(offset), .tgt_we(tgt_we), .rdata(rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [31:0] a, input logic r, input logic w, input logic [1:0] s);
    addr = a; rd_en = r; wr_en = w; size = s;
    #1;
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic clk_store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    addr = a; wdata = d; size = s; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic chk_dec(input string req, input logic [31:0] a,
                         input logic [9:0] es, input logic [21:0] eo);
    bus(a, 1'b1, 1'b0, 2'd2);
    chk({req, " sel"}, 32'(sel), 32'(es));
    chk({req, " offset"}, 32'(offset), 32'(eo));
    idle();
  endtask

  task automatic ram_we(input string req, input logic exp);
    bus(RAMA, 1'b0, 1'b1, 2'd2);
    chk(req, 32'(tgt_we), 32'(exp));
    idle();
  endtask

  task automatic t_reset();
    bus(CTRL, 1'b1, 1'b0, 2'd2);
    chk("R10 control word after reset", rdata, 32'd0);
    idle();
    ram_we("R10 RAM store open after reset", 1'b1);
    bus(RAMA, 1'b0, 1'b0, 2'd2);
    chk("R11 rdata idle", rdata, 32'd0);
  endtask

  task automatic t_ram();
    chk_dec("R1 RAM 0x8012_3456", 32'h8012_3456, 10'h001, 22'h12_3456);
    chk_dec("R1 RAM mirror 0xA07F_0010", 32'hA07F_0010, 10'h001, 22'h1F_0010);
    chk_dec("R1 RAM physical 0x0020_0004", 32'h0020_0004, 10'h001, 22'h00_0004);
    chk_dec("R1 key 0x0080 unmapped", 32'h0080_0000, 10'h000, 22'h0);
  endtask

  task automatic t_local();
    chk_dec("R2 scratchpad top", 32'h1F80_0FFC, 10'h002, 22'h0FFC);
    chk_dec("R2 hw port start", 32'h1F80_1000, 10'h004, 22'h1000);
    chk_dec("R2 hw port uncached view", 32'hBF80_1070, 10'h004, 22'h1070);
  endtask

  task automatic t_ports();
    chk_dec("R3 aux port", 32'h1F40_0004, 10'h008, 22'h0004);
    chk_dec("R3 expansion port", 32'h1000_0020, 10'h010, 22'h0020);
    chk_dec("R3 sound port", 32'h1F90_0200, 10'h020, 22'h0200);
    chk_dec("R3 ipc bank", 32'h1D00_0040, 10'h040, 22'h0040);
    bus(32'h1F40_0004, 1'b0, 1'b1, 2'd0);
    chk("R3 aux store passes", 32'(tgt_we), 32'd1);
    idle();
  endtask

  task automatic t_rom();
    chk_dec("R4 boot ROM", 32'hBFC0_1234, 10'h080, 22'h00_1234);
    chk_dec("R4 boot ROM last page", 32'h1FFF_0008, 10'h080, 22'h3F_0008);
    chk_dec("R4 second ROM", 32'h1E03_0010, 10'h100, 22'h03_0010);
    chk_dec("R9 past second ROM", 32'h1E04_0000, 10'h000, 22'h0);
    bus(32'hBFC0_0000, 1'b0, 1'b1, 2'd2);
    chk("R4 boot ROM store dropped", 32'(tgt_we), 32'd0);
    bus(32'h1E00_0000, 1'b0, 1'b1, 2'd1);
    chk("R4 second ROM store dropped", 32'(tgt_we), 32'd0);
    idle();
  endtask

  task automatic t_unmapped();
    bus(32'h1234_5678, 1'b1, 1'b1, 2'd2);
    chk("R9 unmapped sel", 32'(sel), 32'd0);
    chk("R9 unmapped offset", 32'(offset), 32'd0);
    chk("R9 unmapped rdata", rdata, 32'd0);
    chk("R9 unmapped we", 32'(tgt_we), 32'd0);
    idle();
  endtask

  task automatic t_ctrl();
    chk_dec("R5 control word", CTRL, 10'h200, 22'h0);
    chk_dec("R5 ROM alias 0xBFFE_0130", 32'hBFFE_0130, 10'h080, 22'h3E_0130);
    chk_dec("R5 ROM neighbour 0xFFFE_0134", 32'hFFFE_0134, 10'h080, 22'h3E_0134);
    clk_store(CTRL, 32'h0000_1234, 2'd2);
    bus(CTRL, 1'b1, 1'b0, 2'd0);
    chk("R5 control readback 8-bit load", rdata, 32'h0000_1234);
    bus(CTRL, 1'b0, 1'b1, 2'd2);
    chk("R5 control store no target strobe", 32'(tgt_we), 32'd0);
    idle();
    clk_store(CTRL, 32'h0001_E988, 2'd1);
    bus(CTRL, 1'b1, 1'b0, 2'd2);
    chk("R5 16-bit store ignored", rdata, 32'h0000_1234);
    idle();
    clk_store(32'hBFFE_0130, 32'h0000_0800, 2'd2);
    bus(CTRL, 1'b1, 1'b0, 2'd2);
    chk("R5 ROM alias store leaves word", rdata, 32'h0000_1234);
    idle();
    ram_we("R5 ROM alias store leaves lock", 1'b1);
  endtask

  task automatic t_lock_codes();
    logic [31:0] codes [7] = '{32'h800, 32'h804, 32'hC00, 32'hC04, 32'hCC0, 32'hCC4, 32'h0C4};
    for (int i = 0; i < 7; i++) begin
      clk_store(CTRL, 32'h0001_EDD8, 2'd2);
      ram_we("R7 unlock before code", 1'b1);
      clk_store(CTRL, codes[i], 2'd2);
      ram_we($sformatf("R6 lock code %h", codes[i]), 1'b0);
    end
  endtask

  task automatic t_locked();
    clk_store(CTRL, 32'h0001_E988, 2'd2);
    clk_store(CTRL, 32'h0000_0C00, 2'd2);
    ram_we("R6 RAM store blocked next cycle", 1'b0);
    bus(RAMA, 1'b0, 1'b1, 2'd0);
    chk("R8 8-bit RAM store blocked", 32'(tgt_we), 32'd0);
    bus(RAMA, 1'b1, 1'b0, 2'd2);
    chk("R8 32-bit RAM load zero", rdata, 32'd0);
    bus(RAMA, 1'b1, 1'b0, 2'd1);
    chk("R8 16-bit RAM load passes", rdata, 32'hA5A5_1234);
    bus(32'h1F80_0010, 1'b0, 1'b1, 2'd2);
    chk("R8 scratchpad store passes", 32'(tgt_we), 32'd1);
    idle();
    clk_store(CTRL, 32'h0000_5555, 2'd2);
    bus(CTRL, 1'b1, 1'b0, 2'd2);
    chk("R7 other value stored", rdata, 32'h0000_5555);
    idle();
    ram_we("R7 other value keeps lock", 1'b0);
    clk_store(CTRL, 32'h0001_EDD8, 2'd2);
    ram_we("R7 unlock reopens RAM", 1'b1);
    clk_store(CTRL, 32'h0000_5555, 2'd2);
    ram_we("R7 other value keeps unlocked", 1'b1);
    bus(RAMA, 1'b1, 1'b0, 2'd2);
    chk("R8 RAM load passes when open", rdata, 32'hA5A5_1234);
    idle();
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_local();
    t_ports();
    t_rom();
    t_unmapped();
    t_ctrl();
    t_lock_codes();
    t_locked();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule